// File: doc/BRIEF.md
# Clock source switch sequencer

This block moves the system clock from a slow secondary oscillator back to the main oscillator. It only hands over once the main source can be trusted. A software select input names the wanted source. When that input asks for the main source, a mode-dependent wait runs, counted in main-oscillator periods. A crystal needs a start-up interval. A crystal feeding a frequency multiplier needs that interval plus a lock interval. A resistor-capacitor network or an external clock needs only a handful of edges.

While the wait runs, a stall output holds instruction execution. The ready result crosses into the secondary-clock domain through a two-flop synchroniser. There it is aligned to the end of a four-quarter instruction cycle before the handover is declared. A glitch-free multiplexer then moves the system clock. Each side is gated off or on only at its own falling edge, and only after the other side is seen to be off.

If the select input returns to the secondary source before the handover, the wait is abandoned and its counters cleared. After a handover, the same input moves the system clock straight back. Assumptions: the select input changes on the secondary clock's timebase, and the mode code is changed only while the block is held in reset.

Top module: `oscsw_seq`

## Requirements
- R1: While rst_n is low (sampled at each clock's own edges), stall is 1, switch_done is 0 and sys_clk follows sec_clk.
- R2: Mode codes 0, 1, 2 and 3 (resistor-capacitor, resistor-capacitor with the clock pin free, external clock, external clock with the pin free) need only EDGE_CYCLES (8) main_clk periods of waiting. sys_clk then follows main_clk.
- R3: Mode code 4 (crystal), and the unused codes 6 and 7, wait START_CYCLES (1024) main_clk periods. sys_clk then follows main_clk.
- R4: Mode code 5 (crystal with multiplier) waits START_CYCLES and then PLL_LOCK_CYCLES more main_clk periods. sys_clk then follows pll_clk.
- R5: The ready result crosses into the sec_clk domain through two flops. Number the sec_clk rising edges after reset release from 1. switch_done rises only on an edge whose number is a multiple of 4, which is the close of quarter Q4.
- R6: With the main source wanted, stall stays 1 until switch_done rises. It falls on the same sec_clk edge.
- R7: sys_clk shows no high or low phase shorter than half a period of the fastest source. The two clock gates are never enabled together. A gate opens or closes only at its own clock's falling edge.
- R8: If use_secondary = 1 is sampled before the handover, switch_done stays 0 and stall falls. This also holds when it is sampled on the very edge that would have completed the handover. sys_clk stays on sec_clk, and a later request restarts the full wait from zero.
- R9: If use_secondary = 1 is sampled after the handover, switch_done and stall are 0 from that edge on, and sys_clk returns to sec_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sec_clk | input | 1 | Slow secondary oscillator clock |
| main_clk | input | 1 | Main oscillator clock; all wait counters run on it |
| pll_clk | input | 1 | Multiplied clock, used as the main side in mode 5 |
| rst_n | input | 1 | Synchronous active-low reset, held for several sec_clk periods |
| osc_mode | input | 3 | Main-oscillator mode code (0..5, see R2 to R4) |
| use_secondary | input | 1 | Software select: 1 asks for sec_clk, 0 asks for the main source |
| sys_clk | output | 1 | Glitch-free system clock |
| switch_done | output | 1 | 1 once the handover to the main source is complete |
| stall | output | 1 | 1 while execution must wait for the handover |

## Verification
Two functions can land on the same sec_clk edge. One is the return to the secondary source. The other is the aligned completion of the handover, where the synchronised ready flag is high and quarter Q4 closes. The bench first runs an undisturbed external-clock switch and records the edge number at which switch_done rose. It then repeats the same reset exactly and raises use_secondary so that it is sampled on that recorded edge. The abort has to win: switch_done must stay 0, stall must drop, and sys_clk must keep the secondary rate.

// File: rtl/oscsw_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock source switch sequencer: the main-oscillator
// mode codes, the wait phases and helpers that classify a mode.
package oscsw_pkg;

    localparam logic [2:0] MODE_RC    = 3'd0;
    localparam logic [2:0] MODE_RCIO  = 3'd1;
    localparam logic [2:0] MODE_EC    = 3'd2;
    localparam logic [2:0] MODE_ECIO  = 3'd3;
    localparam logic [2:0] MODE_HS    = 3'd4;
    localparam logic [2:0] MODE_HSPLL = 3'd5;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_LOCK  = 2'd2,
        PH_READY = 2'd3
    } wait_phase_t;

    // Modes without a crystal need only a short edge count.
    function automatic logic mode_is_edge_only(input logic [2:0] m);
        return (m <= MODE_ECIO);
    endfunction

    // Only the multiplied crystal mode adds the lock interval.
    function automatic logic mode_uses_pll(input logic [2:0] m);
        return (m == MODE_HSPLL);
    endfunction

endpackage

// File: rtl/oscsw_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a small bus of independent level signals.
// Assumes each bit is a slow level; no bus coherence is implied.
module oscsw_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/oscsw_wait_timer.sv
`timescale 1ns/1ps
// Mode-dependent stability wait, clocked by the main oscillator itself.
// Counts EDGE_CYCLES or START_CYCLES periods, then PLL_LOCK_CYCLES more in the
// multiplied mode, and raises main_ready. Dropping the request clears it all.
// Assumes osc_mode is static outside reset.
module oscsw_wait_timer
    import oscsw_pkg::*;
#(
    parameter int START_CYCLES    = 1024,
    parameter int EDGE_CYCLES     = 8,
    parameter int PLL_LOCK_CYCLES = 8000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       main_clk,
    input  logic       rst_n,
    input  logic       want_main,
    input  logic [2:0] osc_mode,
    output logic       main_ready
);
    localparam int MAX_A   = (START_CYCLES > EDGE_CYCLES) ? START_CYCLES : EDGE_CYCLES;
    localparam int MAX_LEN = (MAX_A > PLL_LOCK_CYCLES) ? MAX_A : PLL_LOCK_CYCLES;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic        req;
    wait_phase_t phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] start_last;
    logic [CW-1:0] lock_last;

    oscsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk   (main_clk),
        .rst_n (rst_n),
        .d     (want_main),
        .q     (req)
    );

    // Last count value of the first wait stage for the configured mode.
    always_comb begin
        start_last = mode_is_edge_only(osc_mode) ? CW'(EDGE_CYCLES - 1)
                                                 : CW'(START_CYCLES - 1);
    end

    assign lock_last = CW'(PLL_LOCK_CYCLES - 1);

    // Walk the wait phases; any loss of the request aborts to idle.
    always_ff @(posedge main_clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!req) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_START;
                    cnt   <= '0;
                end
                PH_START: begin
                    if (cnt == start_last) begin
                        cnt   <= '0;
                        phase <= mode_uses_pll(osc_mode) ? PH_LOCK : PH_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOCK: begin
                    if (cnt == lock_last) begin
                        cnt   <= '0;
                        phase <= PH_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_READY;
            endcase
        end
    end

    assign main_ready = (phase == PH_READY);

    // A withdrawn request must leave the counters cleared.
    assert_abort_clears_R8: assert property (@(posedge main_clk) disable iff (!rst_n)
        !req |=> (phase == PH_IDLE && cnt == '0));

    // The lock stage is only ever entered in the multiplied mode.
    assert_lock_only_pll_R4: assert property (@(posedge main_clk) disable iff (!rst_n)
        (phase == PH_LOCK) |-> mode_uses_pll(osc_mode));

    // The start stage ends exactly on its last count.
    assert_start_ends_R3: assert property (@(posedge main_clk) disable iff (!rst_n)
        (req && phase == PH_START && cnt == start_last) |=> (phase != PH_START));

    // Ready only ever follows a completed wait stage.
    assert_ready_after_wait_R2: assert property (@(posedge main_clk) disable iff (!rst_n)
        $rose(main_ready) |-> ($past(phase) == PH_START || $past(phase) == PH_LOCK));
endmodule

// File: rtl/oscsw_handover.sv
`timescale 1ns/1ps
// Secondary-domain handover control. Tracks the instruction-cycle quarter
// phase, accepts the synchronised ready flag only at the close of the last
// quarter, and drives switch_done and stall. A ready flag still high from an
// earlier request is ignored until it has been seen low (the armed flag).
// Assumes want_main is synchronous to sec_clk.
module oscsw_handover #(
    parameter int PHASES = 4
) (
    input  logic sec_clk,
    input  logic rst_n,
    input  logic want_main,
    input  logic done_sec,
    output logic switch_done,
    output logic stall
);
    localparam int QW = $clog2(PHASES);
    localparam logic [QW-1:0] Q_LAST = QW'(PHASES - 1);

    logic [QW-1:0] quarter;
    logic          armed;
    logic          take;

    assign take = want_main & armed & done_sec & (switch_done | (quarter == Q_LAST));

    // Advance the quarter phase and register the handover decision.
    always_ff @(posedge sec_clk) begin
        if (!rst_n) begin
            quarter     <= '0;
            armed       <= 1'b0;
            switch_done <= 1'b0;
            stall       <= 1'b1;
        end else begin
            quarter     <= (quarter == Q_LAST) ? '0 : quarter + 1'b1;
            armed       <= want_main & (armed | ~done_sec);
            switch_done <= take;
            stall       <= want_main & ~take;
        end
    end

    // The handover completes only where the last quarter closes.
    assert_align_q4_R5: assert property (@(posedge sec_clk) disable iff (!rst_n)
        $rose(switch_done) |-> ($past(quarter) == Q_LAST));

    // The handover needs the synchronised ready flag.
    assert_done_needs_sync_R5: assert property (@(posedge sec_clk) disable iff (!rst_n)
        $rose(switch_done) |-> $past(done_sec));

    // Stall is released only by a handover or a return to the secondary source.
    assert_stall_release_R6: assert property (@(posedge sec_clk) disable iff (!rst_n)
        $fell(stall) |-> (switch_done || !$past(want_main)));

    // Asking for the secondary source clears both outputs at once.
    assert_back_to_secondary_R9: assert property (@(posedge sec_clk) disable iff (!rst_n)
        !want_main |=> (!switch_done && !stall));
endmodule

// File: rtl/oscsw_clk_leg.sv
`timescale 1ns/1ps
// One leg of the glitch-free clock multiplexer. The select and the other
// leg's enable are synchronised onto this leg's clock. The leg arms only when
// selected and the other leg is off, and its gate enable changes only at its
// own falling edge, when the clock is low.
module oscsw_clk_leg #(
    parameter bit RESET_ON    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_en,
    output logic en,
    output logic gated
);
    localparam logic [1:0] SYNC_RST = {RESET_ON, ~RESET_ON};

    logic [1:0] s;
    logic       arm;

    oscsw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sel_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({want, other_en}),
        .q     (s)
    );

    // Decide on the rising edge whether this leg may drive.
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= RESET_ON;
        else        arm <= s[1] & ~s[0];
    end

    // Move the gate enable only while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) en <= RESET_ON;
        else        en <= arm;
    end

    assign gated = clk & en;
endmodule

// File: rtl/oscsw_seq.sv
`timescale 1ns/1ps
// Clock source switch sequencer top. Runs the mode-dependent wait on the
// main oscillator, carries the ready flag into the secondary domain, aligns
// the handover to the instruction-cycle quarters and steers a glitch-free
// two-leg clock multiplexer. The main side is pll_clk in the multiplied mode,
// otherwise main_clk; osc_mode must not change outside reset.
module oscsw_seq
    import oscsw_pkg::*;
#(
    parameter int START_CYCLES    = 1024,
    parameter int EDGE_CYCLES     = 8,
    parameter int PLL_LOCK_CYCLES = 8000,
    parameter int SYNC_STAGES     = 2,
    parameter int PHASES          = 4
) (
    input  logic       sec_clk,
    input  logic       main_clk,
    input  logic       pll_clk,
    input  logic       rst_n,
    input  logic [2:0] osc_mode,
    input  logic       use_secondary,
    output logic       sys_clk,
    output logic       switch_done,
    output logic       stall
);
    localparam int LEGS = 2;

    logic            want_main;
    logic            main_ready;
    logic            done_sec;
    logic            main_side_clk;
    logic [LEGS-1:0] leg_clk;
    logic [LEGS-1:0] leg_want;
    logic [LEGS-1:0] leg_en;
    logic [LEGS-1:0] leg_gated;

    assign want_main     = ~use_secondary;
    assign main_side_clk = mode_uses_pll(osc_mode) ? pll_clk : main_clk;

    oscsw_wait_timer #(
        .START_CYCLES    (START_CYCLES),
        .EDGE_CYCLES     (EDGE_CYCLES),
        .PLL_LOCK_CYCLES (PLL_LOCK_CYCLES),
        .SYNC_STAGES     (SYNC_STAGES)
    ) u_timer (
        .main_clk   (main_clk),
        .rst_n      (rst_n),
        .want_main  (want_main),
        .osc_mode   (osc_mode),
        .main_ready (main_ready)
    );

    oscsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk   (sec_clk),
        .rst_n (rst_n),
        .d     (main_ready),
        .q     (done_sec)
    );

    oscsw_handover #(.PHASES(PHASES)) u_handover (
        .sec_clk     (sec_clk),
        .rst_n       (rst_n),
        .want_main   (want_main),
        .done_sec    (done_sec),
        .switch_done (switch_done),
        .stall       (stall)
    );

    // Leg 0 carries the secondary clock and is on after reset; leg 1 the main side.
    assign leg_clk  = {main_side_clk, sec_clk};
    assign leg_want = {switch_done, ~switch_done};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        oscsw_clk_leg #(
            .RESET_ON    ((g == 0) ? 1'b1 : 1'b0),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_leg (
            .clk      (leg_clk[g]),
            .rst_n    (rst_n),
            .want     (leg_want[g]),
            .other_en (leg_en[LEGS-1-g]),
            .en       (leg_en[g]),
            .gated    (leg_gated[g])
        );
    end

    assign sys_clk = |leg_gated;

    // The two gates must never be open together.
    assert_one_leg_open_R7: assert property (@(posedge main_clk) disable iff (!rst_n)
        !(leg_en[0] && leg_en[1]));

    // The secondary gate stays open across the whole reset.
    assert_reset_on_secondary_R1: assert property (@(posedge sec_clk)
        $past(!rst_n) && !rst_n |-> (leg_en[0] && stall && !switch_done));
endmodule

// File: tb/oscsw_seq_bench.sv
`timescale 1ns/1ps
module oscsw_seq_bench;
    localparam int LOCK     = 200;
    localparam int WIN_NS   = 200;
    localparam int SEC_EDGES = 5;

    // Stimulus/expectation table, one row per mode code: wait in main periods
    // and sys_clk rising edges expected in a 200 ns window afterwards.
    localparam int EXP_WAIT  [8] = '{8, 8, 8, 8, 1024, 1024 + LOCK, 1024, 1024};
    localparam int EXP_EDGES [8] = '{40, 40, 40, 40, 40, 160, 40, 40};

    logic       main_clk = 1'b0;
    logic       pll_clk  = 1'b0;
    logic       sec_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic       use_secondary = 1'b0;
    logic       sys_clk;
    logic       switch_done;
    logic       stall;

    int  checks = 0;
    int  fails  = 0;
    int  sec_k  = 0;
    int  sys_edges = 0;
    int  runts = 0;
    bit  finished = 1'b0;
    realtime t_rel = 0.0;
    realtime last_t = 0.0;

    always #2.5 main_clk = ~main_clk;
    always #0.625 pll_clk = ~pll_clk;
    initial begin
        #1.3;
        forever #20 sec_clk = ~sec_clk;
    end

    oscsw_seq #(.PLL_LOCK_CYCLES(LOCK)) u_oscsw_seq (
        .sec_clk       (sec_clk),
        .main_clk      (main_clk),
        .pll_clk       (pll_clk),
        .rst_n         (rst_n),
        .osc_mode      (osc_mode),
        .use_secondary (use_secondary),
        .sys_clk       (sys_clk),
        .switch_done   (switch_done),
        .stall         (stall)
    );

    always @(posedge sec_clk) begin
        if (!rst_n) sec_k <= 0;
        else        sec_k <= sec_k + 1;
    end

    always @(posedge sys_clk) sys_edges++;

    // R7 runt monitor: every sys_clk phase must last at least 0.6 ns.
    always @(sys_clk) begin
        if (rst_n && ($realtime - t_rel) > 50.0 && ($realtime - last_t) < 0.6) runts++;
        last_t = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic count_sys(input int win, output int n);
        int e0;
        e0 = sys_edges;
        #(win);
        n = sys_edges - e0;
        #1;
    endtask

    function automatic string mode_req(input int m);
        if (m < 4)  return "R2";
        if (m == 5) return "R4";
        return "R3";
    endfunction

    // Hold reset, check the reset state (R1), then release on a sec_clk falling edge.
    task automatic apply_reset(input int m);
        int n;
        @(negedge sec_clk);
        rst_n = 1'b0;
        osc_mode = 3'(m);
        use_secondary = 1'b0;
        repeat (3) @(negedge sec_clk);
        check(stall === 1'b1, "R1", "stall in reset", longint'(stall), 1);
        check(switch_done === 1'b0, "R1", "switch_done in reset", longint'(switch_done), 0);
        count_sys(WIN_NS, n);
        check(n >= SEC_EDGES - 1 && n <= SEC_EDGES + 1, "R1", "sys_clk edges in reset", n, SEC_EDGES);
        repeat (2) @(negedge sec_clk);
        rst_n = 1'b1;
        t_rel = $realtime;
    endtask

    task automatic wait_done(output int k_at, output realtime t_at, output bit ok);
        ok = 1'b0;
        k_at = 0;
        t_at = 0.0;
        for (int i = 0; i < 400; i++) begin
            @(negedge sec_clk);
            if (switch_done === 1'b1) begin
                k_at = sec_k;
                t_at = $realtime;
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_mode(input int m);
        int k;
        int n;
        int el;
        int w;
        bit ok;
        realtime t;
        w = EXP_WAIT[m];
        apply_reset(m);
        @(negedge sec_clk);
        check(stall === 1'b1 && switch_done === 1'b0, "R6", "stall held during wait",
              longint'(stall), 1);
        wait_done(k, t, ok);
        check(ok, mode_req(m), "handover seen", longint'(ok), 1);
        el = $rtoi(t - t_rel);
        check(el >= w * 5 && el <= w * 5 + 40 + 480, mode_req(m), "wait length ns", el, w * 5);
        check(k % 4 == 0, "R5", "handover edge number mod 4", k % 4, 0);
        check(stall === 1'b0, "R6", "stall released with handover", longint'(stall), 0);
        #200;
        count_sys(WIN_NS, n);
        check(n >= EXP_EDGES[m] - 2 && n <= EXP_EDGES[m] + 2, mode_req(m), "sys_clk edges on main side",
              n, EXP_EDGES[m]);
    endtask

    initial begin
        int k1;
        int n;
        int el;
        bit ok;
        realtime t;
        realtime t0;

        // Table walk over every mode code (R1 to R6).
        for (int m = 0; m < 8; m++) run_mode(m);

        // Same-edge collision: abort sampled on the edge that would complete the handover (R8, R5).
        apply_reset(2);
        wait_done(k1, t, ok);
        check(ok && k1 >= 2, "R8", "reference run handover edge", k1, 4);
        apply_reset(2);
        while (sec_k < k1 - 1) @(negedge sec_clk);
        use_secondary = 1'b1;
        @(negedge sec_clk);
        check(switch_done === 1'b0, "R8", "abort wins on handover edge", longint'(switch_done), 0);
        check(stall === 1'b0, "R8", "stall dropped on abort", longint'(stall), 0);
        repeat (6) @(negedge sec_clk);
        check(switch_done === 1'b0, "R8", "no late handover", longint'(switch_done), 0);
        count_sys(WIN_NS, n);
        check(n >= SEC_EDGES - 1 && n <= SEC_EDGES + 1, "R8", "sys_clk stays secondary", n, SEC_EDGES);

        // Abort mid-wait in crystal mode, then a fresh request restarts the full wait (R8).
        apply_reset(4);
        repeat (40) @(negedge sec_clk);
        check(switch_done === 1'b0 && stall === 1'b1, "R6", "mid-wait state", longint'(stall), 1);
        use_secondary = 1'b1;
        repeat (4) @(negedge sec_clk);
        check(stall === 1'b0 && switch_done === 1'b0, "R8", "aborted wait state", longint'(stall), 0);
        use_secondary = 1'b0;
        t0 = $realtime;
        wait_done(k1, t, ok);
        el = $rtoi(t - t0);
        check(ok && el >= 1024 * 5 && el <= 1024 * 5 + 40 + 480, "R8", "restarted wait ns", el, 1024 * 5);

        // Return to the secondary source after a handover (R9).
        use_secondary = 1'b1;
        @(negedge sec_clk);
        check(switch_done === 1'b0, "R9", "switch_done after return", longint'(switch_done), 0);
        check(stall === 1'b0, "R9", "stall after return", longint'(stall), 0);
        #200;
        count_sys(WIN_NS, n);
        check(n >= SEC_EDGES - 1 && n <= SEC_EDGES + 1, "R9", "sys_clk back on secondary", n, SEC_EDGES);

        check(runts == 0, "R7", "short sys_clk phases", runts, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule